// File: doc/BRIEF.md
# Loopback-Capable Ethernet Frame Serializer

This block takes frame bytes that a host has placed in a small transmit FIFO and sends them as a serial Ethernet frame, one bit per clock. Each frame opens with seven preamble bytes and a start-of-frame byte. The payload follows, and an optional 32-bit frame check sequence closes it. A byte counter is loaded from `byte_count` when `start` is accepted. It counts down once for each byte taken from the FIFO, and the frame ends when the counter reaches zero.

A control input `crc_inh` selects the check-sequence source. With hardware CRC the block computes the CRC-32 over the payload and appends it. With software CRC no check sequence is added, so the last byte read from the FIFO is the last byte on the wire. The serial stream goes either to the line pins or, in internal loopback, to a separate pair of pins that feeds a local receiver.

When a frame finishes, a sticky packet-sent flag rises and a status byte is written. The flag is cleared by `irq_ack`. While a frame is in flight, `busy` is high and further `start` pulses are ignored. A low-water flag compares the FIFO occupancy with a programmable threshold so the host knows when to start a refill burst.

Top module: `lbtx_frame_tx`

## Requirements
- R1: The first 56 serial bits after an accepted start alternate 1,0,1,0… beginning with 1. The next 8 bits are the start-of-frame value 0xD5 sent least significant bit first.
- R2: Payload bytes follow the start-of-frame byte, each sent least significant bit first, in FIFO order. `bytes_left` is loaded with `byte_count` on start and drops by one in the cycle when each payload byte begins.
- R3: With `crc_inh`=0, four bytes follow the payload. They are the complemented reflected CRC-32 of the payload (polynomial 0xEDB88320, preset all ones), sent least significant byte first. For payload ASCII "123456789" these 32 bits read as 0xCBF43926.
- R4: With `crc_inh`=1, no bytes are added, and the final bit on the wire is bit 7 of the last byte read from the FIFO.
- R5: In the cycle after the last bit, the enables are low, `busy` is low and `ptx` is high. `ptx` stays high until `irq_ack`. For a good frame on the line pins, `tx_status` reads 0x03.
- R6: With `loop_int`=1 at start, the bits appear on `lb_en`/`lb_bit`, `line_en` stays low, and a good frame gives `tx_status` 0x53.
- R7: A `start` pulse while `busy` is high is ignored, and no second frame follows.
- R8: A start with `byte_count`=0 sends no bits. It sets `ptx` in the next cycle with `tx_status` 0x08, and `busy` stays low.
- R9: If a byte is needed while the FIFO is empty, the frame stops after the last complete byte, and `ptx` rises with `tx_status` 0x08.
- R10: `refill_req` is high exactly when `fifo_level` is below `fill_thresh`.
- R11: Writes to a full FIFO are dropped, and `fifo_level` never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | FIFO write byte |
| fill_thresh | input | LVL_W | Low-water threshold |
| fifo_level | output | LVL_W | Bytes held in the FIFO |
| refill_req | output | 1 | Occupancy below threshold |
| start | input | 1 | Begin a frame |
| crc_inh | input | 1 | 1 = software CRC, none appended |
| loop_int | input | 1 | 1 = internal loopback |
| byte_count | input | CNT_W | Payload length in bytes |
| irq_ack | input | 1 | Clears `ptx` |
| busy | output | 1 | Frame in progress |
| ptx | output | 1 | Sticky packet-sent flag |
| tx_status | output | 8 | Completion code |
| bytes_left | output | CNT_W | Bytes still to take from the FIFO |
| line_en | output | 1 | Line bit valid |
| line_bit | output | 1 | Line serial data |
| lb_en | output | 1 | Loopback bit valid |
| lb_bit | output | 1 | Loopback serial data |

## Verification
The hardest situation to reach is the FIFO running dry partway through a frame, because a well-behaved host never lets that happen. The bench produces it on purpose in two ways. In one, it programs a byte count larger than the number of bytes written, so the FIFO empties during the payload. In the other, it writes no bytes at all, so the FIFO is empty at the start-of-frame boundary. A `start` pulse is also injected mid-frame to show that the busy lockout holds.

// File: rtl/lbtx_pkg.sv
package lbtx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SFD,
    PH_DATA,
    PH_FCS
  } phase_t;

  localparam logic [7:0]  PRE_BYTE   = 8'h55;
  localparam logic [7:0]  SYNC_BYTE  = 8'hD5;
  localparam logic [7:0]  ST_OK_EXT  = 8'h03;
  localparam logic [7:0]  ST_OK_LOOP = 8'h53;
  localparam logic [7:0]  ST_FAIL    = 8'h08;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
  localparam int          PRE_BYTES  = 7;
endpackage

// File: rtl/lbtx_fifo.sv
module lbtx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/lbtx_crc32.sv
module lbtx_crc32
  import lbtx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic        din,
  output logic [31:0] crc_nxt
);
  logic [31:0] crc_q;

  // one bit of the reflected division per clock
  assign crc_nxt = (crc_q >> 1) ^ ({32{crc_q[0] ^ din}} & CRC_POLY);

  always_ff @(posedge clk) begin
    if (rst || init) crc_q <= '1;
    else if (en)     crc_q <= crc_nxt;
  end
endmodule

// File: rtl/lbtx_seq.sv
module lbtx_seq
  import lbtx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             crc_inh,
  input  logic             loop_int,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             irq_ack,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_data,
  output logic             fifo_rd,
  output logic             crc_init,
  output logic             crc_en,
  output logic             crc_bit,
  input  logic [31:0]      crc_nxt,
  output logic             ser_en,
  output logic             ser_bit,
  output logic             loop_q,
  output logic             busy,
  output logic             ptx,
  output logic [7:0]       tx_status,
  output logic [CNT_W-1:0] bytes_left
);
  phase_t      phase;
  logic [7:0]  sh;
  logic [2:0]  bitn;
  logic [2:0]  pcnt;
  logic [31:0] fcs;
  logic        inh_q;
  logic        byte_end;
  logic        need_byte;

  assign byte_end  = (phase != PH_IDLE) && (bitn == 3'd7);
  assign need_byte = byte_end &&
                     ((phase == PH_SFD) || (phase == PH_DATA && bytes_left != '0));
  assign fifo_rd   = need_byte && !fifo_empty;
  assign crc_init  = (phase == PH_IDLE);
  assign crc_en    = (phase == PH_DATA);
  assign crc_bit   = sh[0];
  assign ser_en    = (phase != PH_IDLE);
  assign ser_bit   = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      sh         <= '0;
      bitn       <= '0;
      pcnt       <= '0;
      fcs        <= '0;
      inh_q      <= 1'b0;
      loop_q     <= 1'b0;
      busy       <= 1'b0;
      ptx        <= 1'b0;
      tx_status  <= '0;
      bytes_left <= '0;
    end else begin
      if (irq_ack) ptx <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          loop_q <= loop_int;
          inh_q  <= crc_inh;
          if (byte_count == '0) begin
            ptx       <= 1'b1;
            tx_status <= ST_FAIL;
          end else begin
            phase      <= PH_PRE;
            sh         <= PRE_BYTE;
            bitn       <= '0;
            pcnt       <= '0;
            bytes_left <= byte_count;
            busy       <= 1'b1;
          end
        end
      end else if (!byte_end) begin
        sh   <= sh >> 1;
        bitn <= bitn + 3'd1;
      end else begin
        bitn <= '0;
        if (phase == PH_PRE) begin
          if (pcnt == 3'(PRE_BYTES - 1)) begin
            sh    <= SYNC_BYTE;
            phase <= PH_SFD;
          end else begin
            sh   <= PRE_BYTE;
            pcnt <= pcnt + 3'd1;
          end
        end else if (need_byte) begin
          if (fifo_empty) begin
            phase     <= PH_IDLE;
            busy      <= 1'b0;
            ptx       <= 1'b1;
            tx_status <= ST_FAIL;
          end else begin
            sh         <= fifo_data;
            bytes_left <= bytes_left - CNT_W'(1);
            phase      <= PH_DATA;
          end
        end else if (phase == PH_DATA && !inh_q) begin
          phase <= PH_FCS;
          sh    <= ~crc_nxt[7:0];
          fcs   <= ~crc_nxt;
          pcnt  <= '0;
        end else if (phase == PH_FCS && pcnt != 3'd3) begin
          sh   <= fcs[15:8];
          fcs  <= fcs >> 8;
          pcnt <= pcnt + 3'd1;
        end else begin
          phase     <= PH_IDLE;
          busy      <= 1'b0;
          ptx       <= 1'b1;
          tx_status <= loop_q ? ST_OK_LOOP : ST_OK_EXT;
        end
      end
    end
  end
endmodule

// File: rtl/lbtx_frame_tx.sv
module lbtx_frame_tx #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [LVL_W-1:0] fill_thresh,
  output logic [LVL_W-1:0] fifo_level,
  output logic             refill_req,
  input  logic             start,
  input  logic             crc_inh,
  input  logic             loop_int,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             irq_ack,
  output logic             busy,
  output logic             ptx,
  output logic [7:0]       tx_status,
  output logic [CNT_W-1:0] bytes_left,
  output logic             line_en,
  output logic             line_bit,
  output logic             lb_en,
  output logic             lb_bit
);
  logic        f_rd, f_empty, f_full;
  logic [7:0]  f_data;
  logic        c_init, c_en, c_bit;
  logic [31:0] c_nxt;
  logic        s_en, s_bit, s_loop;

  lbtx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(f_rd), .rd_data(f_data), .empty(f_empty), .full(f_full),
    .level(fifo_level)
  );

  lbtx_crc32 u_crc (
    .clk(clk), .rst(rst), .init(c_init), .en(c_en), .din(c_bit),
    .crc_nxt(c_nxt)
  );

  lbtx_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .crc_inh(crc_inh),
    .loop_int(loop_int), .byte_count(byte_count), .irq_ack(irq_ack),
    .fifo_empty(f_empty), .fifo_data(f_data), .fifo_rd(f_rd),
    .crc_init(c_init), .crc_en(c_en), .crc_bit(c_bit), .crc_nxt(c_nxt),
    .ser_en(s_en), .ser_bit(s_bit), .loop_q(s_loop), .busy(busy),
    .ptx(ptx), .tx_status(tx_status), .bytes_left(bytes_left)
  );

  assign refill_req = (fifo_level < fill_thresh);
  assign line_en    = s_en && !s_loop;
  assign line_bit   = s_bit && line_en;
  assign lb_en      = s_en && s_loop;
  assign lb_bit     = s_bit && lb_en;

  logic unused_full;
  assign unused_full = f_full;
endmodule

// File: rtl/lbtx_chk.sv
module lbtx_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = AW + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             ptx,
  input logic             line_en,
  input logic             lb_en,
  input logic [7:0]       tx_status,
  input logic [LVL_W-1:0] fifo_level,
  input logic [CNT_W-1:0] bytes_left
);
  AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(line_en && lb_en)); // R6
  AST_EN_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (line_en || lb_en) |-> busy); // R7
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R7
  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LVL_W'(DEPTH)); // R11
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(ptx) |-> (!busy && !line_en && !lb_en)); // R5
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
    $rose(ptx) |-> (tx_status == 8'h03 || tx_status == 8'h53 || tx_status == 8'h08)); // R5
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (bytes_left <= $past(bytes_left))); // R2
endmodule

bind lbtx_frame_tx lbtx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .ptx(ptx),
  .line_en(line_en), .lb_en(lb_en), .tx_status(tx_status),
  .fifo_level(fifo_level), .bytes_left(bytes_left)
);

// File: tb/sim_lbtx_frame_tx.sv
`timescale 1ns/1ps
module sim_lbtx_frame_tx;
  localparam int DEPTH = 16;
  localparam int CNT_W = 16;
  localparam int LVL_W = $clog2(DEPTH) + 1;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [LVL_W-1:0] fill_thresh = LVL_W'(4);
  logic [LVL_W-1:0] fifo_level;
  logic refill_req;
  logic start = 1'b0, crc_inh = 1'b0, loop_int = 1'b0, irq_ack = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic busy, ptx, line_en, line_bit, lb_en, lb_bit;
  logic [7:0] tx_status;
  logic [CNT_W-1:0] bytes_left;

  int checks = 0;
  int errors = 0;
  int model_level = 0;
  logic [31:0] obs_tail;

  always #5 clk = ~clk;

  lbtx_frame_tx #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .fill_thresh(fill_thresh), .fifo_level(fifo_level), .refill_req(refill_req),
    .start(start), .crc_inh(crc_inh), .loop_int(loop_int),
    .byte_count(byte_count), .irq_ack(irq_ack), .busy(busy), .ptx(ptx),
    .tx_status(tx_status), .bytes_left(bytes_left), .line_en(line_en),
    .line_bit(line_bit), .lb_en(lb_en), .lb_bit(lb_bit)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(bq_t d);
    logic [31:0] c = '1;
    foreach (d[i]) begin
      c ^= {24'h0, d[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic push(input bq_t d);
    foreach (d[i]) begin
      wr_en = 1'b1;
      wr_data = d[i];
      @(negedge clk);
      if (model_level < DEPTH) model_level++;
      chk(fifo_level == LVL_W'(model_level), "R11 level", 32'(fifo_level), 32'(model_level));
      chk(refill_req == (model_level < int'(fill_thresh)), "R10 refill",
          32'(refill_req), 32'(model_level < int'(fill_thresh)));
    end
    wr_en = 1'b0;
  endtask

  task automatic run_frame(input bq_t d, input int cnt, input bit inh,
                           input bit lp, input bit poke);
    bit eb[$];
    int nsent, popped;
    bit under;
    logic [31:0] f;
    logic [7:0] exp_st;
    under = (cnt > d.size());
    nsent = under ? d.size() : cnt;
    for (int i = 0; i < 56; i++) eb.push_back(i % 2 == 0);
    for (int i = 0; i < 8; i++) eb.push_back(8'hD5 >> i);
    for (int b = 0; b < nsent; b++)
      for (int i = 0; i < 8; i++) eb.push_back(d[b][i]);
    if (!under && !inh) begin
      f = ref_crc(d);
      for (int i = 0; i < 32; i++) eb.push_back(f[i]);
    end
    exp_st = under ? 8'h08 : (lp ? 8'h53 : 8'h03);
    byte_count = CNT_W'(cnt);
    crc_inh = inh;
    loop_int = lp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    foreach (eb[i]) begin
      if (i > 0) @(negedge clk);
      popped = (i < 64) ? 0 : (((i - 64) / 8 + 1 < nsent) ? (i - 64) / 8 + 1 : nsent);
      chk((lp ? lb_en : line_en) == 1'b1, "R1 enable", 0, 1);
      chk((lp ? line_en : lb_en) == 1'b0, "R6 unused port quiet", 1, 0);
      chk((lp ? lb_bit : line_bit) == eb[i], "R2 serial bit",
          32'(lp ? lb_bit : line_bit), 32'(eb[i]));
      chk(bytes_left == CNT_W'(cnt - popped), "R2 bytes_left",
          32'(bytes_left), 32'(cnt - popped));
      obs_tail = {(lp ? lb_bit : line_bit), obs_tail[31:1]};
      if (poke && i == 10) start = 1'b1;
      if (poke && i == 11) start = 1'b0;
    end
    @(negedge clk);
    chk(!line_en && !lb_en, "R5 enables low at end", 32'({line_en, lb_en}), 0);
    chk(!busy, "R5 busy low", 32'(busy), 0);
    chk(ptx, "R5 ptx set", 32'(ptx), 1);
    chk(tx_status == exp_st, under ? "R9 status" : (lp ? "R6 status" : "R5 status"),
        32'(tx_status), 32'(exp_st));
    chk(bytes_left == CNT_W'(cnt - nsent), "R2 final count", 32'(bytes_left),
        32'(cnt - nsent));
    model_level = 0;
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk(!ptx, "R5 ptx cleared by ack", 32'(ptx), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bq_t d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !ptx && !line_en && !lb_en, "R5 reset idle",
        32'({busy, ptx, line_en, lb_en}), 0);
    chk(tx_status == 8'h00 && fifo_level == '0, "R11 reset level",
        32'(fifo_level), 0);
    chk(refill_req, "R10 refill after reset", 32'(refill_req), 1);

    // hardware CRC, line pins, known check vector
    d = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    push(d);
    run_frame(d, 9, 1'b0, 1'b0, 1'b0);
    chk(obs_tail == 32'hCBF43926, "R3 fcs check value", obs_tail, 32'hCBF43926);

    // software CRC, internal loopback; last FIFO byte ends the frame (R4)
    d = {8'hA0, 8'h0F, 8'hFF, 8'h00, 8'h5A, 8'hC3, 8'h12, 8'h34, 8'h56, 8'h81};
    push(d);
    run_frame(d, 10, 1'b1, 1'b1, 1'b0);
    chk(obs_tail[31:24] == 8'h81, "R4 last byte", 32'(obs_tail[31:24]), 32'h81);

    // overfill FIFO (R11), then a full-depth loopback frame with start poke (R7)
    d = {};
    for (int i = 0; i < DEPTH + 2; i++) d.push_back(8'(i * 37 + 5));
    push(d);
    d = d[0:DEPTH-1];
    run_frame(d, DEPTH, 1'b0, 1'b1, 1'b1);
    repeat (30) begin
      @(negedge clk);
      chk(!line_en && !lb_en && !busy, "R7 no second frame", 32'({line_en, lb_en}), 0);
    end

    // zero length (R8)
    byte_count = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ptx && !busy && !line_en && !lb_en, "R8 zero length flags",
        32'({ptx, busy}), 32'h2);
    chk(tx_status == 8'h08, "R8 status", 32'(tx_status), 32'h08);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;

    // underrun mid-payload and at the start-of-frame boundary (R9)
    d = {8'h11, 8'hE7};
    push(d);
    run_frame(d, 5, 1'b0, 1'b0, 1'b0);
    d = {};
    run_frame(d, 3, 1'b0, 1'b1, 1'b0);

    // threshold sweep (R10)
    fill_thresh = LVL_W'(2);
    d = {8'h01, 8'h02, 8'h03};
    push(d);
    run_frame(d, 3, 1'b1, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule